// File: doc/BRIEF.md
# Three-Source Powerdown Controller

This block turns three powerdown requests into clock-enable outputs for the clock domains of an audio processor. It also drives the shutdown pin of an external amplifier. The first request is a hardware pin. It is asynchronous, passes through a two-flop synchroniser, and stops every clock, including those of the host control interfaces. The second is a partial-powerdown register bit. It suspends the core, DSP and output-stage clocks but keeps the serial control link and the two-wire control bus clocked, so the host can write the bit back to zero and wake the device. A third register bit drives the amplifier shutdown output directly. When the PLL bypass is selected, the PLL powerdown output is asserted.

Stopping is immediate once a request is seen. Resuming is staged: the core enable returns first, then the DSP enable, then the output-stage enable, one clock apart. This limits the current step at wake-up. The pin request takes priority over the register request.

Top module: `pwrdn_ctrl`

## Requirements
- R1: While the synchronised pin request is high, every bit of `ctl_en_o` and `stage_en_o` is 0.
- R2: A change on `pin_pwdn_i` reaches `ctl_en_o` after exactly two rising clock edges. When the pin is released, `ctl_en_o` becomes all ones after the second edge.
- R3: With the synchronised pin low and `part_pwdn_i` high, `ctl_en_o` is all ones and `stage_en_o` is 0 in the same cycle, with no clock edge in between.
- R4: When both the pin request and `part_pwdn_i` are active, the pin wins: `ctl_en_o` is 0.
- R5: Resume order follows the `stage_en_o` bits: bit 0 is core, bit 1 is DSP and bit 2 is the output stages. After the first rising edge with no active request, the value is 3'b001, then 3'b011, then 3'b111, one edge apart.
- R6: `amp_pwdn_o` follows `amp_pwdn_i` combinationally.
- R7: `pll_pd_o` follows `pll_bypass_i` combinationally.
- R8: Reset state: the synchroniser resets to "no request", so `ctl_en_o` is all ones and `stage_en_o` is 0 while reset is held.
- R9: A request raised partway through a resume clears all of `stage_en_o` at once. Once the request is removed, the resume starts again from core alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_pwdn_i | input | 1 | Asynchronous full-powerdown pin request |
| part_pwdn_i | input | 1 | Partial-powerdown register bit |
| amp_pwdn_i | input | 1 | Amplifier-powerdown register bit |
| pll_bypass_i | input | 1 | PLL bypass select |
| ctl_en_o | output | 2 | Clock enables for control link (bit 0) and control bus (bit 1) |
| stage_en_o | output | 3 | Clock enables: core (0), DSP (1), output stages (2) |
| amp_pwdn_o | output | 1 | External amplifier shutdown |
| pll_pd_o | output | 1 | PLL powerdown |

## Verification
The pin request and the partial-powerdown bit can be active in the same cycle. A register-driven wake-up can also overlap with a pin assertion that has not yet cleared the synchroniser. The bench applies every combination of the two requests together with the two direct bits. It holds each combination long enough to settle and checks that a pin request always silences the control clocks, whatever the register bit says. Separate directed passes release each request at the falling edge and sample each resume step just after the rising edges that follow. One pass raises the register bit in the middle of a resume to confirm that the stages collapse and restart from the core.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
  localparam int unsigned N_CTL_DOM   = 2;
  localparam int unsigned N_STAGE_DOM = 3;
  localparam int unsigned SYNC_DEPTH  = 2;

  typedef enum int unsigned {
    STG_CORE = 0,
    STG_DSP  = 1,
    STG_OUT  = 2
  } stage_idx_e;
endpackage

// File: rtl/pwrdn_sync.sv
module pwrdn_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[DEPTH-2:0], async_i};
  end

  assign sync_o = chain_q[DEPTH-1];
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
  parameter int unsigned N_STG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  output logic [N_STG-1:0] en_o
);
  localparam int unsigned CW = $clog2(N_STG + 1);
  localparam logic [CW-1:0] TOP = CW'(N_STG);

  logic [CW-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           lvl_q <= '0;
    else if (hold_i)       lvl_q <= '0;
    else if (lvl_q != TOP) lvl_q <= lvl_q + 1'b1;
  end

  // stop is combinational, wake is one stage per edge
  for (genvar k = 0; k < N_STG; k++) begin : g_stage
    assign en_o[k] = !hold_i && (32'(lvl_q) > k);
  end

  for (genvar k = 1; k < N_STG; k++) begin : g_order
    // R5: a later stage never runs without the one before it
    p_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_o[k] |-> en_o[k-1]);
  end

  // R5/R9: at most one stage wakes per edge
  p_one_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en_o) <= $countones($past(en_o)) + 1);
endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pwrdn_pkg::*;
#(
  parameter int unsigned N_CTL = N_CTL_DOM,
  parameter int unsigned N_STG = N_STAGE_DOM,
  parameter int unsigned SYNC  = SYNC_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_pwdn_i,
  input  logic             part_pwdn_i,
  input  logic             amp_pwdn_i,
  input  logic             pll_bypass_i,
  output logic [N_CTL-1:0] ctl_en_o,
  output logic [N_STG-1:0] stage_en_o,
  output logic             amp_pwdn_o,
  output logic             pll_pd_o
);
  logic pin_s;
  logic hold;

  pwrdn_sync #(.DEPTH(SYNC)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_pwdn_i),
    .sync_o  (pin_s)
  );

  // pin outranks the register bit
  assign hold     = pin_s || part_pwdn_i;
  assign ctl_en_o = {N_CTL{!pin_s}};

  pwrdn_seq #(.N_STG(N_STG)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .en_o   (stage_en_o)
  );

  assign amp_pwdn_o = amp_pwdn_i;
  assign pll_pd_o   = pll_bypass_i;

  // R1: control clocks off implies every stage off
  p_full_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_en_o == '0) |-> (stage_en_o == '0));

  // R3: register request keeps control clocks, drops stages
  p_part_keep_ctl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (part_pwdn_i && ctl_en_o != '0) |-> (stage_en_o == '0 && ctl_en_o == '1));

  // R4: control enables all on or all off
  p_ctl_uniform_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_en_o == '0) || (ctl_en_o == '1));
endmodule

// File: tb/pwrdn_ctrl_tb.sv
module pwrdn_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0, part = 1'b0, amp = 1'b0, byp = 1'b0;
  logic [1:0] ctl_en;
  logic [2:0] stg_en;
  logic amp_o, pll_o;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwrdn_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_pwdn_i(pin), .part_pwdn_i(part),
    .amp_pwdn_i(amp), .pll_bypass_i(byp), .ctl_en_o(ctl_en),
    .stage_en_o(stg_en), .amp_pwdn_o(amp_o), .pll_pd_o(pll_o)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic edge_after();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R8 ctl reset", 8'(ctl_en), 8'h3);
    chk("R8 stage reset", 8'(stg_en), 8'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) edge_after();
    chk("R5 ramp after reset", 8'(stg_en), 8'h7);

    // steady sweep over every input combination
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      {pin, part, amp, byp} = 4'(v);
      #1;
      chk("R6 amp", 8'(amp_o), 8'(amp));
      chk("R7 pll", 8'(pll_o), 8'(byp));
      repeat (6) edge_after();
      chk(pin ? "R1/R4 ctl" : "R3 ctl", 8'(ctl_en), pin ? 8'h0 : 8'h3);
      chk((pin || part) ? "R1/R3 stage" : "R5 stage", 8'(stg_en),
          (pin || part) ? 8'h0 : 8'h7);
    end

    // resume from register request
    @(negedge clk); {pin, part, amp, byp} = 4'b0000;
    repeat (5) edge_after();
    @(negedge clk); part = 1'b1; #1;
    chk("R3 same-cycle stop", 8'(stg_en), 8'h0);
    chk("R3 ctl alive", 8'(ctl_en), 8'h3);
    repeat (2) edge_after();
    @(negedge clk); part = 1'b0; #1;
    chk("R5 before edge", 8'(stg_en), 8'h0);
    edge_after(); chk("R5 core", 8'(stg_en), 8'h1);
    edge_after(); chk("R5 dsp", 8'(stg_en), 8'h3);
    edge_after(); chk("R5 out", 8'(stg_en), 8'h7);

    // pin assertion latency
    @(negedge clk); pin = 1'b1;
    edge_after(); chk("R2 one edge ctl", 8'(ctl_en), 8'h3);
    chk("R2 one edge stage", 8'(stg_en), 8'h7);
    edge_after(); chk("R2 two edges ctl", 8'(ctl_en), 8'h0);
    chk("R1 stage", 8'(stg_en), 8'h0);
    repeat (2) edge_after();

    // pin release latency and ramp
    @(negedge clk); pin = 1'b0;
    edge_after(); chk("R2 release one edge", 8'(ctl_en), 8'h0);
    edge_after(); chk("R2 release two edges", 8'(ctl_en), 8'h3);
    chk("R5 stage still off", 8'(stg_en), 8'h0);
    edge_after(); chk("R5 pin core", 8'(stg_en), 8'h1);
    edge_after(); chk("R5 pin dsp", 8'(stg_en), 8'h3);
    edge_after(); chk("R5 pin out", 8'(stg_en), 8'h7);

    // R4 pin with register bit, register bit released while pin held
    @(negedge clk); pin = 1'b1; part = 1'b1;
    repeat (3) edge_after();
    chk("R4 both ctl", 8'(ctl_en), 8'h0);
    @(negedge clk); part = 1'b0;
    repeat (3) edge_after();
    chk("R4 pin still wins", 8'(stg_en), 8'h0);
    @(negedge clk); pin = 1'b0;
    repeat (5) edge_after();
    chk("R5 after both", 8'(stg_en), 8'h7);

    // R9 request mid-ramp
    @(negedge clk); part = 1'b1;
    edge_after();
    @(negedge clk); part = 1'b0;
    edge_after(); chk("R9 core", 8'(stg_en), 8'h1);
    edge_after(); chk("R9 dsp", 8'(stg_en), 8'h3);
    @(negedge clk); part = 1'b1; #1;
    chk("R9 collapse", 8'(stg_en), 8'h0);
    edge_after();
    @(negedge clk); part = 1'b0;
    edge_after(); chk("R9 restart core", 8'(stg_en), 8'h1);
    edge_after(); chk("R9 restart dsp", 8'(stg_en), 8'h3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule